// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block is the sequencing core of a three-value combination lock. The user keys in the code one value at a time. An external comparator checks each value against one stored code word, and this block tells the comparator which word to use through a select output. A one-cycle strobe marks each new keyed value. When the strobe is high, the comparator's match flag decides what happens next. A match moves the lock to the next code word, or opens it after the last word. A mismatch drops the lock into a fault state.

The open and fault states are terminal, and only a synchronous reset leaves them. Every output is decoded from the registered state alone, so each output changes one clock edge after the strobe that caused the change. The code storage, the comparator and any key debouncing sit outside this block. The number of code words is a parameter. With the default of three, the select encoding is two bits wide.

Top module: `lock_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state returns to the first checking step. After that edge `code_sel` is 2'b01, `lock_closed` is 1 and `lock_open` is 0.
- R2: In checking steps one, two and three, `code_sel` reads 2'b01, 2'b10 and 2'b11 respectively. In every checking step `lock_closed` is 1 and `lock_open` is 0.
- R3: A strobe with `match` high in step one or step two moves the lock to the following step at the next edge.
- R4: A strobe with `match` high in step three opens the lock at the next edge. In the open state `lock_open` is 1, `lock_closed` is 0 and `code_sel` is 2'b00.
- R5: A strobe with `match` low in any checking step moves the lock to the fault state at the next edge. In the fault state `code_sel` is 2'b00, `lock_closed` is 1 and `lock_open` is 0.
- R6: While `key_strobe` is low, the state does not change, whatever the value of `match`.
- R7: The open state is kept under any strobe or match input until reset.
- R8: The fault state is kept under any strobe or match input until reset, including a strobe with `match` high.
- R9: Exactly one of `lock_open` and `lock_closed` is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| key_strobe | input | 1 | One-cycle pulse marking a newly keyed value |
| match | input | 1 | Comparator result for the value currently selected |
| code_sel | output | 2 | Code word select: 01, 10, 11 for words one to three; 00 once open or faulted |
| lock_open | output | 1 | High in the open state |
| lock_closed | output | 1 | High in every state except open |

## Verification
The hardest cases to reach are a mismatch at the last word and a strobe arriving after the lock has become terminal. Both need a specific run of matching strobes first, and a stray strobe or reset can spoil that run. The stimulus reaches them with scripted runs that reset the lock and then feed exactly k matching strobes, for k from zero to three. A mismatch or a further strobe follows each run. Idle cycles with `match` toggling are interleaved, so that holding is exercised in every step and not only at the start.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic [1:0] {
        PH_CHECK = 2'd0,
        PH_OPEN  = 2'd1,
        PH_FAULT = 2'd2
    } phase_e;

endpackage

// File: rtl/lock_step.sv
module lock_step #(
    parameter int STEPS = 3,
    localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  key_strobe,
    input  logic                  match,
    output lock_pkg::phase_e      phase_q,
    output logic [IDX_W-1:0]      idx_q
);
    import lock_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] idx;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_CHECK: begin
                if (key_strobe) begin
                    if (!match) begin
                        st_d.phase = PH_FAULT;
                    end else if (st_q.idx == LAST_IDX) begin
                        st_d.phase = PH_OPEN;
                    end else begin
                        st_d.idx = st_q.idx + IDX_W'(1);
                    end
                end
            end
            PH_OPEN:  st_d = st_q;
            PH_FAULT: st_d = st_q;
            default:  st_d.phase = PH_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_CHECK, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_q = st_q.phase;
    assign idx_q   = st_q.idx;

endmodule

// File: rtl/lock_decode.sv
module lock_decode #(
    parameter int STEPS = 3,
    localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1,
    localparam int SEL_W = $clog2(STEPS + 1)
) (
    input  lock_pkg::phase_e      phase_q,
    input  logic [IDX_W-1:0]      idx_q,
    output logic [SEL_W-1:0]      code_sel,
    output logic                  lock_open,
    output logic                  lock_closed
);
    import lock_pkg::*;

    always_comb begin
        code_sel    = '0;
        lock_open   = 1'b0;
        lock_closed = 1'b1;
        unique case (phase_q)
            PH_CHECK: code_sel = SEL_W'(idx_q) + SEL_W'(1);
            PH_OPEN: begin
                lock_open   = 1'b1;
                lock_closed = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm #(
    parameter int STEPS = 3,
    localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1,
    localparam int SEL_W = $clog2(STEPS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_strobe,
    input  logic             match,
    output logic [SEL_W-1:0] code_sel,
    output logic             lock_open,
    output logic             lock_closed
);
    lock_pkg::phase_e  phase_q;
    logic [IDX_W-1:0]  idx_q;

    lock_step #(.STEPS(STEPS)) u_step (
        .clk        (clk),
        .rst        (rst),
        .key_strobe (key_strobe),
        .match      (match),
        .phase_q    (phase_q),
        .idx_q      (idx_q)
    );

    lock_decode #(.STEPS(STEPS)) u_decode (
        .phase_q     (phase_q),
        .idx_q       (idx_q),
        .code_sel    (code_sel),
        .lock_open   (lock_open),
        .lock_closed (lock_closed)
    );

endmodule

// File: rtl/lock_fsm_chk.sv
module lock_fsm_chk #(
    parameter int STEPS = 3,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             key_strobe,
    input logic             match,
    input logic [SEL_W-1:0] code_sel,
    input logic             lock_open,
    input logic             lock_closed
);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(STEPS);

    logic checking, faulted;
    assign checking = (code_sel != '0);
    assign faulted  = (code_sel == '0) && !lock_open;

    p_reset_first_r1: assert property (@(posedge clk)
        rst |=> (code_sel == SEL_W'(1)) && lock_closed && !lock_open);

    p_check_closed_r2: assert property (@(posedge clk) disable iff (rst)
        checking |-> lock_closed && !lock_open);

    p_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (key_strobe && match && checking && code_sel != LAST_SEL)
        |=> code_sel == $past(code_sel) + SEL_W'(1));

    p_unlock_r4: assert property (@(posedge clk) disable iff (rst)
        (key_strobe && match && code_sel == LAST_SEL)
        |=> lock_open && !lock_closed && code_sel == '0);

    p_fault_r5: assert property (@(posedge clk) disable iff (rst)
        (key_strobe && !match && checking) |=> faulted && lock_closed);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !key_strobe |=> $stable(code_sel) && $stable(lock_open));

    p_open_stays_r7: assert property (@(posedge clk) disable iff (rst)
        lock_open |=> lock_open);

    p_fault_stays_r8: assert property (@(posedge clk) disable iff (rst)
        faulted |=> faulted);

    p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $countones({lock_open, lock_closed}) == 1);

endmodule

bind lock_fsm lock_fsm_chk #(.STEPS(STEPS), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .key_strobe  (key_strobe),
    .match       (match),
    .code_sel    (code_sel),
    .lock_open   (lock_open),
    .lock_closed (lock_closed)
);

// File: tb/test_lock_fsm.sv
module test_lock_fsm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_strobe = 1'b0;
    logic       match = 1'b0;
    logic [1:0] code_sel;
    logic       lock_open, lock_closed;

    typedef struct {
        logic [1:0] sel;
        logic       opn;
        logic       cls;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   mstate = 1;   // 1..3 checking step, 4 open, 5 fault
    bit   done = 0;

    always #2 clk = ~clk;   // 250 MHz

    lock_fsm i_lock_fsm (
        .clk         (clk),
        .rst         (rst),
        .key_strobe  (key_strobe),
        .match       (match),
        .code_sel    (code_sel),
        .lock_open   (lock_open),
        .lock_closed (lock_closed)
    );

    // driver: set inputs, advance the reference model, push the expectation
    task automatic cyc(input logic r, input logic s, input logic m, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; key_strobe = s; match = m;
        if (r) mstate = 1;
        else if (s && mstate <= 3) mstate = m ? mstate + 1 : 5;
        e.tag = tag;
        e.sel = (mstate <= 3) ? 2'(mstate) : 2'b00;
        e.opn = (mstate == 4);
        e.cls = (mstate != 4);
        exp_q.push_back(e);
    endtask

    // monitor: compare once per cycle, away from the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (code_sel !== e.sel || lock_open !== e.opn || lock_closed !== e.cls) begin
                n_bad++;
                $display("FAIL %s: sel=%b open=%b closed=%b expected sel=%b open=%b closed=%b",
                         e.tag, code_sel, lock_open, lock_closed, e.sel, e.opn, e.cls);
            end
        end
    end

    task automatic enter(input int k, input string tag);
        cyc(1, 0, 0, "R1 reset");
        for (int i = 0; i < k; i++) cyc(0, 1, 1, tag);
    endtask

    initial begin
        cyc(1, 0, 0, "R1 reset");
        cyc(1, 1, 1, "R1 reset with strobe");
        // R6: idle in step one while match toggles
        cyc(0, 0, 1, "R6 hold s1");
        cyc(0, 0, 0, "R6 hold s1");
        // R2/R3: walk through the words with idle gaps
        cyc(0, 1, 1, "R3 s1->s2 R2");
        cyc(0, 0, 0, "R6 hold s2");
        cyc(0, 0, 1, "R6 hold s2");
        cyc(0, 1, 1, "R3 s2->s3 R2");
        cyc(0, 0, 0, "R6 hold s3");
        cyc(0, 1, 1, "R4 open R9");
        // R7: open stays under any input
        cyc(0, 1, 0, "R7 open strobe mismatch");
        cyc(0, 1, 1, "R7 open strobe match");
        cyc(0, 0, 0, "R7 open idle");
        // R5/R8: mismatch at each step, then fault persists
        for (int k = 0; k < 3; k++) begin
            enter(k, "R3 advance");
            cyc(0, 0, 0, "R6 hold before miss");
            cyc(0, 1, 0, "R5 fault on mismatch");
            cyc(0, 1, 1, "R8 fault strobe match");
            cyc(0, 1, 0, "R8 fault strobe mismatch");
            cyc(0, 0, 1, "R8 fault idle");
        end
        // R1: reset leaves the open state
        enter(3, "R4 path");
        cyc(0, 0, 0, "R7 open idle");
        cyc(1, 0, 0, "R1 reset from open");
        cyc(0, 1, 1, "R3 after reset");
        // R1: reset leaves the fault state
        cyc(0, 1, 0, "R5 fault");
        cyc(1, 1, 0, "R1 reset from fault");
        cyc(0, 0, 0, "R2 s1 after reset");
        repeat (3) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000ns;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule